// File: doc/BRIEF.md
# Low-speed USB packet transmitter

This block drives a low-speed USB bus pair from a byte source. When a send is requested it first places the idle J state on its output registers. It then turns on the output drivers and holds J for one bit time. After that it shifts out a sync byte and the payload bytes, least-significant bit first. The bits are NRZI-encoded, with a stuffed toggle after any run of six ones. The packet closes with two bit times of SE0 and one bit time of J, and then the drivers are released. Each bit lasts a fixed number of clocks, eight at the nominal rate of 1.5 Mbit/s.

The byte source is read ahead of the serializer. The block raises a one-clock request and takes the byte present on `data_in` in that same clock. The first payload byte is fetched while the drivers are being turned on, and each later byte is fetched as its predecessor starts to go out. Because of this there is never an idle gap between bytes. A handshake short-cut sends the sync byte and a single PID byte taken from a port, without touching the byte source.

The block also keeps a device address register. A pending address is copied into it when a data packet has been fully sent, but not when a handshake has been sent.

Top module: `ls_usb_tx`

## Requirements
- R1: After reset, `drv_oe`, `dp_out`, `dm_out`, `busy`, `done` and `data_req` are low and `dev_addr` is zero.
- R2: A `start` seen while idle makes `busy` high in the next clock. That clock has J on the lines (`dp_out`=0, `dm_out`=1) with `drv_oe` low. Then `drv_oe` is high with J for CLKS_PER_BIT clocks, and the first bit slot begins CLKS_PER_BIT+1 clocks after the accepting edge.
- R3: The byte order on the wire is the sync byte 0x80 first and then the payload bytes in source order, each sent bit 0 first. `byte_count` counts the sync byte, and a count of 0 or 1 sends the sync byte alone.
- R4: Each bit slot lasts CLKS_PER_BIT clocks. A 0 bit swaps the line between J (dp 0, dm 1) and K (dp 1, dm 0), and a 1 bit leaves it unchanged. Both lines are never high together.
- R5: After six consecutive 1 bits, counted across byte boundaries, one extra toggling slot is inserted and the run count restarts. This includes a run that ends on the last bit of the packet.
- R6: After the last bit, both lines are low for two bit times and then J for one bit time. On the following clock `drv_oe`, `dp_out` and `dm_out` go low.
- R7: `busy` stays high from the clock after the accepted `start` until the drivers are released. `done` is high for exactly one clock, the first clock with `busy` low.
- R8: `data_req` is a one-clock pulse, and `data_in` is taken in the clock that holds it. The first pulse comes in the clock after `start` if at least one payload byte exists. Each further pulse comes in the last clock of the slot before a payload byte's first bit, and only when a byte after that one exists.
- R9: With `hs_mode` high at `start`, the packet is the sync byte followed by `hs_pid`. `byte_count` and `data_in` are ignored and `data_req` stays low.
- R10: When the drivers are released after a data packet and `addr_pend_valid` is high, `dev_addr` takes `addr_pend`. After a handshake packet, or when the pending address is not valid, `dev_addr` is unchanged.
- R11: A `start` while `busy` is high has no effect on the packet in flight or on the state after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLKS_PER_BIT times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to send one packet (taken only when idle) |
| hs_mode | input | 1 | Send the sync byte plus `hs_pid` instead of a sourced payload |
| hs_pid | input | 8 | Handshake PID byte |
| byte_count | input | CNT_W | Bytes in the packet including the sync byte |
| data_in | input | 8 | Next payload byte from the source |
| data_req | output | 1 | Source byte taken this clock |
| addr_pend | input | ADDR_W | Address waiting to be committed |
| addr_pend_valid | input | 1 | `addr_pend` holds a value to commit |
| dp_out | output | 1 | D+ drive level |
| dm_out | output | 1 | D- drive level |
| drv_oe | output | 1 | Output driver enable for both lines |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-clock pulse at bus release |
| dev_addr | output | ADDR_W | Committed device address |

## Verification
The bench builds the block with CLKS_PER_BIT=4, CNT_W=5 and STUFF_RUN=6. The shorter bit keeps each packet to a few hundred clocks, so many packets fit in one run. With these values the bench can reach six-one runs that cross byte boundaries and a stuffed bit just before the end of packet. It also covers sync-only packets from counts of 0 and 1, and both handshake PIDs. A behavioural model expands every byte into bit slots and compares the line levels, driver enable, busy, done and fetch pulses on every clock. It also tracks the address register across a mix of handshake and data packets.

// File: rtl/ls_usb_tx_pkg.sv
package ls_usb_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_ACQ,
    ST_SEND,
    ST_SE0,
    ST_EOPJ
  } tx_state_t;

  typedef enum logic [2:0] {
    LC_NONE,
    LC_PREP_J,
    LC_ENABLE,
    LC_TOGGLE,
    LC_SE0,
    LC_DRIVE_J,
    LC_RELEASE
  } line_cmd_t;

  localparam logic [7:0] SYNC_BYTE = 8'h80;

  // {dp, dm} for a given line state
  function automatic logic [1:0] line_of(input logic is_k);
    return is_k ? 2'b10 : 2'b01;
  endfunction

  // NRZI: a zero data bit swaps the line state
  function automatic logic nrzi_toggle(input logic data_bit);
    return ~data_bit;
  endfunction

  // a stuffed slot is owed once the run of ones reaches the limit
  function automatic logic stuff_due(input int run, input int limit);
    return run >= limit;
  endfunction

endpackage

// File: rtl/ls_tx_bit_timer.sv
module ls_tx_bit_timer #(
  parameter int CLKS_PER_BIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/ls_tx_serializer.sv
module ls_tx_serializer
  import ls_usb_tx_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int STUFF_RUN = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             in_prep,
  input  logic             first_tick,
  input  logic             data_tick,
  input  logic             hs_mode,
  input  logic [7:0]       hs_pid,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [7:0]       data_in,
  output logic             data_req,
  output logic             toggle,
  output logic             pkt_end
);
  localparam int RUN_W = $clog2(STUFF_RUN + 1);

  logic             hs_q;
  logic [CNT_W-1:0] left_q;   // bytes still to follow the one in the shifter
  logic [7:0]       nb_q;     // next byte, fetched one byte ahead
  logic [7:0]       sh_q;
  logic [3:0]       bi_q;     // bits of the current byte already sent
  logic [RUN_W-1:0] run_q;    // consecutive ones on the wire, crosses bytes

  logic stuff_now, byte_empty, load_next, plain_emit, cur_bit;

  assign stuff_now  = data_tick && stuff_due(int'(run_q), STUFF_RUN);
  assign byte_empty = (bi_q == 4'd8);
  assign load_next  = data_tick && !stuff_now && byte_empty && (left_q != '0);
  assign pkt_end    = data_tick && !stuff_now && byte_empty && (left_q == '0);
  assign plain_emit = data_tick && !stuff_now && !byte_empty;
  assign cur_bit    = load_next ? nb_q[0] : sh_q[0];

  assign toggle = first_tick || stuff_now ||
                  ((load_next || plain_emit) && nrzi_toggle(cur_bit));

  assign data_req = !hs_q &&
                    ((in_prep && (left_q != '0)) ||
                     (load_next && (left_q >= CNT_W'(2))));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q   <= 1'b0;
      left_q <= '0;
      nb_q   <= '0;
      sh_q   <= '0;
      bi_q   <= '0;
      run_q  <= '0;
    end else begin
      if (accept) begin
        hs_q <= hs_mode;
        if (hs_mode) begin
          left_q <= CNT_W'(1);
          nb_q   <= hs_pid;
        end else begin
          left_q <= (byte_count == '0) ? '0 : byte_count - CNT_W'(1);
        end
      end
      if (data_req) begin
        nb_q <= data_in;
      end
      if (first_tick) begin
        // bit 0 of the sync byte is a zero: the run restarts here
        sh_q  <= SYNC_BYTE >> 1;
        bi_q  <= 4'd1;
        run_q <= '0;
      end else if (stuff_now) begin
        run_q <= '0;
      end else if (load_next) begin
        sh_q   <= {1'b0, nb_q[7:1]};
        bi_q   <= 4'd1;
        left_q <= left_q - CNT_W'(1);
        run_q  <= nb_q[0] ? run_q + RUN_W'(1) : '0;
      end else if (plain_emit) begin
        sh_q  <= {1'b0, sh_q[7:1]};
        bi_q  <= bi_q + 4'd1;
        run_q <= sh_q[0] ? run_q + RUN_W'(1) : '0;
      end
    end
  end
endmodule

// File: rtl/ls_tx_line_driver.sv
module ls_tx_line_driver
  import ls_usb_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_cmd_t cmd,
  output logic      dp_out,
  output logic      dm_out,
  output logic      drv_oe
);
  logic k_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q    <= 1'b0;
      dp_out <= 1'b0;
      dm_out <= 1'b0;
      drv_oe <= 1'b0;
    end else begin
      unique case (cmd)
        LC_PREP_J: begin
          k_q              <= 1'b0;
          {dp_out, dm_out} <= line_of(1'b0);
          drv_oe           <= 1'b0;
        end
        LC_ENABLE: drv_oe <= 1'b1;
        LC_TOGGLE: begin
          k_q              <= ~k_q;
          {dp_out, dm_out} <= line_of(~k_q);
        end
        LC_SE0:    {dp_out, dm_out} <= 2'b00;
        LC_DRIVE_J: begin
          k_q              <= 1'b0;
          {dp_out, dm_out} <= line_of(1'b0);
        end
        LC_RELEASE: begin
          drv_oe           <= 1'b0;
          {dp_out, dm_out} <= 2'b00;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ls_usb_tx.sv
module ls_usb_tx
  import ls_usb_tx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 8,
  parameter int CNT_W        = 8,
  parameter int STUFF_RUN    = 6,
  parameter int ADDR_W       = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              hs_mode,
  input  logic [7:0]        hs_pid,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [7:0]        data_in,
  output logic              data_req,
  input  logic [ADDR_W-1:0] addr_pend,
  input  logic              addr_pend_valid,
  output logic              dp_out,
  output logic              dm_out,
  output logic              drv_oe,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] dev_addr
);
  tx_state_t state_q, state_d;
  line_cmd_t cmd;
  logic se0_half_q, se0_half_d;
  logic pkt_hs_q;
  logic done_q;
  logic [ADDR_W-1:0] dev_addr_q;

  // named internal events
  logic accept, slot_tick, first_tick, data_tick, toggle, pkt_end, release_evt;
  logic timer_run, timer_clr;

  assign accept     = (state_q == ST_IDLE) && start;
  assign timer_clr  = (state_q == ST_PREP);
  assign timer_run  = (state_q == ST_ACQ) || (state_q == ST_SEND) ||
                      (state_q == ST_SE0) || (state_q == ST_EOPJ);
  assign first_tick = (state_q == ST_ACQ) && slot_tick;
  assign data_tick  = (state_q == ST_SEND) && slot_tick;

  ls_tx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (timer_clr),
    .run  (timer_run),
    .tick (slot_tick)
  );

  ls_tx_serializer #(.CNT_W(CNT_W), .STUFF_RUN(STUFF_RUN)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .in_prep   (timer_clr),
    .first_tick(first_tick),
    .data_tick (data_tick),
    .hs_mode   (hs_mode),
    .hs_pid    (hs_pid),
    .byte_count(byte_count),
    .data_in   (data_in),
    .data_req  (data_req),
    .toggle    (toggle),
    .pkt_end   (pkt_end)
  );

  ls_tx_line_driver u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (cmd),
    .dp_out(dp_out),
    .dm_out(dm_out),
    .drv_oe(drv_oe)
  );

  always_comb begin
    state_d     = state_q;
    se0_half_d  = se0_half_q;
    cmd         = LC_NONE;
    release_evt = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        cmd     = LC_PREP_J;
        state_d = ST_PREP;
      end
      ST_PREP: begin
        cmd     = LC_ENABLE;
        state_d = ST_ACQ;
      end
      ST_ACQ: if (slot_tick) begin
        cmd     = LC_TOGGLE;
        state_d = ST_SEND;
      end
      ST_SEND: if (slot_tick) begin
        if (pkt_end) begin
          cmd        = LC_SE0;
          state_d    = ST_SE0;
          se0_half_d = 1'b0;
        end else if (toggle) begin
          cmd = LC_TOGGLE;
        end
      end
      ST_SE0: if (slot_tick) begin
        if (!se0_half_q) begin
          se0_half_d = 1'b1;
        end else begin
          cmd     = LC_DRIVE_J;
          state_d = ST_EOPJ;
        end
      end
      ST_EOPJ: if (slot_tick) begin
        cmd         = LC_RELEASE;
        state_d     = ST_IDLE;
        release_evt = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      se0_half_q <= 1'b0;
      pkt_hs_q   <= 1'b0;
      done_q     <= 1'b0;
      dev_addr_q <= '0;
    end else begin
      state_q    <= state_d;
      se0_half_q <= se0_half_d;
      done_q     <= release_evt;
      if (accept) pkt_hs_q <= hs_mode;
      if (release_evt && !pkt_hs_q && addr_pend_valid) dev_addr_q <= addr_pend;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign dev_addr = dev_addr_q;
endmodule

// File: rtl/ls_usb_tx_chk.sv
module ls_usb_tx_chk #(
  parameter int CLKS_PER_BIT = 8,
  parameter int ADDR_W       = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              drv_oe,
  input logic              dp_out,
  input logic              dm_out,
  input logic              data_req,
  input logic [ADDR_W-1:0] dev_addr
);
  logic [15:0] same_run_q;
  logic [1:0]  prev_lines_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      same_run_q   <= '0;
      prev_lines_q <= '0;
    end else begin
      prev_lines_q <= {dp_out, dm_out};
      if (!drv_oe || (!dp_out && !dm_out)) same_run_q <= '0;
      else if ({dp_out, dm_out} != prev_lines_q) same_run_q <= 16'd1;
      else if (same_run_q != 16'hffff) same_run_q <= same_run_q + 16'd1;
    end
  end

  AST_NO_SE1: assert property (@(posedge clk) disable iff (!rst_n)
    !(dp_out && dm_out)); // R4
  AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2
  AST_ENABLE_IN_J: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_oe) |-> (!dp_out && dm_out)); // R2
  AST_OE_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    drv_oe |-> busy); // R7
  AST_RELEASE_FROM_J: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_oe) |-> ($past(dm_out) && !$past(dp_out))); // R6
  AST_RELEASE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_oe) |-> (done && !busy)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_REQ_IN_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |-> busy); // R8
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |=> !data_req); // R8
  AST_ADDR_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(dev_addr)); // R10
  AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    same_run_q <= 16'(7 * CLKS_PER_BIT)); // R5
endmodule

bind ls_usb_tx ls_usb_tx_chk #(.CLKS_PER_BIT(CLKS_PER_BIT), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .drv_oe  (drv_oe),
  .dp_out  (dp_out),
  .dm_out  (dm_out),
  .data_req(data_req),
  .dev_addr(dev_addr)
);

// File: tb/ls_usb_tx_tb.sv
module ls_usb_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CPB        = 4;
  localparam int CW         = 5;
  localparam int AW         = 7;
  localparam int RUNMAX     = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic hs_mode = 1'b0;
  logic [7:0] hs_pid = 8'h00;
  logic [CW-1:0] byte_count = '0;
  logic [7:0] data_in = 8'h00;
  logic data_req;
  logic [AW-1:0] addr_pend = '0;
  logic addr_pend_valid = 1'b0;
  logic dp_out, dm_out, drv_oe, busy, done;
  logic [AW-1:0] dev_addr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ls_usb_tx #(.CLKS_PER_BIT(CPB), .CNT_W(CW), .STUFF_RUN(RUNMAX), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .hs_mode(hs_mode), .hs_pid(hs_pid),
    .byte_count(byte_count), .data_in(data_in), .data_req(data_req),
    .addr_pend(addr_pend), .addr_pend_valid(addr_pend_valid),
    .dp_out(dp_out), .dm_out(dm_out), .drv_oe(drv_oe), .busy(busy), .done(done),
    .dev_addr(dev_addr)
  );

  typedef struct packed {
    logic b, oe, dp, dm, dn, rq;
  } exp_t;

  exp_t exp_q[$];
  logic [7:0] payload [0:15];
  int checks = 0;
  int errors = 0;
  int ptr = 0;
  bit req_seen = 1'b0;
  string cur_tag = "R1";

  function automatic exp_t mk(logic b, logic oe, logic dp, logic dm, logic dn, logic rq);
    exp_t e;
    e.b = b; e.oe = oe; e.dp = dp; e.dm = dm; e.dn = dn; e.rq = rq;
    return e;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic push_slot(input bit is_k);
    for (int c = 0; c < CPB; c++) exp_q.push_back(mk(1, 1, is_k, !is_k, 0, 0));
  endtask

  // expand a packet into expected per-clock outputs
  task automatic build(input bit hs, input logic [7:0] pid, input int cnt);
    logic [7:0] bytes[$];
    bit lvl_k = 1'b0;
    int ones = 0;
    bytes.push_back(8'h80);
    if (hs) bytes.push_back(pid);
    else for (int k = 1; k < cnt; k++) bytes.push_back(payload[k-1]);
    exp_q.push_back(mk(1, 0, 0, 1, 0, !hs && bytes.size() >= 2));
    for (int c = 0; c < CPB; c++) exp_q.push_back(mk(1, 1, 0, 1, 0, 0));
    for (int j = 0; j < bytes.size(); j++) begin
      for (int i = 0; i < 8; i++) begin
        bit bv = bytes[j][i];
        if (i == 0 && j >= 1 && !hs && (j + 1) < bytes.size()) begin
          exp_t e = exp_q[exp_q.size() - 1];
          e.rq = 1'b1;
          exp_q[exp_q.size() - 1] = e;
        end
        if (!bv) lvl_k = !lvl_k;
        push_slot(lvl_k);
        ones = bv ? ones + 1 : 0;
        if (ones == RUNMAX) begin
          lvl_k = !lvl_k;
          push_slot(lvl_k);
          ones = 0;
        end
      end
    end
    for (int c = 0; c < 2 * CPB; c++) exp_q.push_back(mk(1, 1, 0, 0, 0, 0));
    for (int c = 0; c < CPB; c++) exp_q.push_back(mk(1, 1, 0, 1, 0, 0));
    exp_q.push_back(mk(0, 0, 0, 0, 1, 0));
  endtask

  task automatic step();
    exp_t e;
    @(negedge clk);
    e = (exp_q.size() != 0) ? exp_q.pop_front() : mk(0, 0, 0, 0, 0, 0);
    chk({dp_out, dm_out} == {e.dp, e.dm}, cur_tag, "lines", {dp_out, dm_out}, {e.dp, e.dm});
    chk(!(dp_out && dm_out), "R4", "se1", {dp_out, dm_out}, 0);
    chk(drv_oe == e.oe, "R6", "drv_oe", drv_oe, e.oe);
    chk(busy == e.b, "R7", "busy", busy, e.b);
    chk(done == e.dn, "R7", "done", done, e.dn);
    chk(data_req == e.rq, "R8", "data_req", data_req, e.rq);
    if (req_seen) ptr++;
    data_in = payload[ptr[3:0]];
    req_seen = data_req;
  endtask

  // issue one packet; optionally pulse start again while busy (R11)
  task automatic send(input bit hs, input logic [7:0] pid, input int cnt, input string tag, input int pulse_at);
    int n = 0;
    cur_tag = tag;
    ptr = 0;
    req_seen = 1'b0;
    data_in = payload[0];
    hs_mode = hs;
    hs_pid = pid;
    byte_count = CW'(cnt);
    start = 1'b1;
    build(hs, pid, cnt);
    step();
    start = 1'b0;
    chk(busy && !drv_oe && dm_out && !dp_out, "R2", "prep_j", {busy, drv_oe, dp_out, dm_out}, 9);
    while (exp_q.size() != 0) begin
      n++;
      if (pulse_at != 0 && n == pulse_at) begin
        start = 1'b1; hs_mode = !hs; byte_count = CW'(3);
      end
      if (pulse_at != 0 && n == pulse_at + 3) start = 1'b0;
      step();
    end
    start = 1'b0;
    repeat (3) step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) payload[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(!drv_oe && !dp_out && !dm_out && !busy && !done && !data_req, "R1", "reset_outputs",
        {drv_oe, dp_out, dm_out, busy, done, data_req}, 0);
    chk(dev_addr == 0, "R1", "reset_addr", dev_addr, 0);
    repeat (2) step();

    // R9: ACK handshake, byte_count and data_in ignored; address stays put (R10)
    addr_pend = 7'd5; addr_pend_valid = 1'b1;
    payload[0] = 8'hAA;
    send(1'b1, 8'hD2, 7, "R9", 0);
    chk(dev_addr == 0, "R10", "addr_after_handshake", dev_addr, 0);

    // R3: three payload bytes after sync, address committed
    payload[0] = 8'hC3; payload[1] = 8'h01; payload[2] = 8'h02;
    send(1'b0, 8'h00, 4, "R3", 0);
    chk(dev_addr == 5, "R10", "addr_after_data", dev_addr, 5);

    // R4: zeros and alternating bits; pending address not valid
    addr_pend = 7'd9; addr_pend_valid = 1'b0;
    payload[0] = 8'h00; payload[1] = 8'h55;
    send(1'b0, 8'h00, 3, "R4", 0);
    chk(dev_addr == 5, "R10", "addr_not_valid", dev_addr, 5);

    // R5: long runs of ones across byte boundaries
    payload[0] = 8'hFF; payload[1] = 8'hFF; payload[2] = 8'hFF;
    send(1'b0, 8'h00, 4, "R5", 0);

    // R5: run of six ones ending the packet
    payload[0] = 8'hFC;
    send(1'b0, 8'h00, 2, "R5", 0);

    // R3: sync-only packets
    send(1'b0, 8'h00, 1, "R3", 0);
    send(1'b0, 8'h00, 0, "R3", 0);

    // R11: NAK with start pulsed while busy; address committed only by data packets
    addr_pend = 7'd17; addr_pend_valid = 1'b1;
    send(1'b1, 8'h5A, 2, "R11", 12);
    chk(dev_addr == 5, "R11", "addr_unchanged", dev_addr, 5);

    // R6: data packet after the ignored pulse ends cleanly and commits
    payload[0] = 8'h7E; payload[1] = 8'h3F;
    send(1'b0, 8'h00, 3, "R6", 0);
    chk(dev_addr == 17, "R10", "addr_second_commit", dev_addr, 17);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule